// File: doc/BRIEF.md
# Shared Serial-Clock Port Pin Controller

This block controls a single bidirectional port pin. A CPU sees three one-bit registers on a byte-wide register bus: the pin's drive direction, its output level and a pulldown-inhibit bit. The block turns these into the pin's output value, output enable and pulldown enable. A synchronous serial peripheral can take over the pin as its clock line. In master mode the peripheral's clock drives the pin. In slave mode the pin is released and its level is handed back to the peripheral.

While the peripheral owns the pin, the CPU can still read and write the port registers. Those accesses have no effect on the pin until serial mode is switched off. At that point the stored register values take effect in the same cycle. Reads of the data register with the direction bit clear return the pin level, sampled through a `SYNC_STAGES`-deep synchronizer. A global option input can block the pulldown outright.

The register bus is plain control: a write takes one cycle and is never stalled, and reads are combinational. No valid/ready flow applies to it.

Top module: `pinctl_sck_pin`

## Requirements
- R1: After reset the direction, data and pulldown-inhibit bits are 0. The pin is then an input (`pin_oe`=0) with `pin_pd_en`=1, provided `pd_inhibit_all`=0.
- R2: A write with `reg_wr`=1 stores bit `BIT_IDX` (7) of `reg_wdata` at the next clock edge, as follows:
  - address 0x01 sets the data bit;
  - address 0x05 sets the direction bit;
  - address 0x11 sets the pulldown-inhibit bit.
  Reading 0x05 returns the direction bit in bit 7. Reading 0x11 or any unmapped address returns 0x00, and writes to unmapped addresses change nothing. All bits other than bit 7 read as 0.
- R3: With `ser_en`=0 and the direction bit at 1, `pin_oe`=1 and `pin_out` equals the data bit. A read of 0x01 returns the data bit.
- R4: With the direction bit at 0, a read of 0x01 returns `pin_in` as it stood `SYNC_STAGES` (2) clock edges earlier.
- R5: With `ser_en`=1, `pin_oe` equals `ser_master`, whatever the direction bit holds.
- R6: With `ser_en`=1 and `ser_master`=1, `pin_out` follows `ser_sck` combinationally.
- R7: With `ser_en`=1 and `ser_master`=0, `pin_oe`=0 and `ser_clk_in` follows `pin_in` combinationally. In every other mode `ser_clk_in` is 0.
- R8: With `ser_en`=1, `pin_pd_en`=0 whatever the pulldown-inhibit bit holds.
- R9: `pin_pd_en`=1 exactly when all four of these are 0: `ser_en`, the direction bit, the pulldown-inhibit bit and `pd_inhibit_all`.
- R10: Register writes made while `ser_en`=1 change neither `pin_oe`, `pin_out` nor `ser_clk_in`. They are still stored and can be read back.
- R11: When `ser_en` falls, `pin_oe`, `pin_out` and `pin_pd_en` take the stored register values without waiting for a clock edge.
- R12: `pd_inhibit_all`=1 forces `pin_pd_en`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | ADDR_W | Register address |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr` |
| ser_en | input | 1 | Serial peripheral owns the pin |
| ser_master | input | 1 | 1 = peripheral drives the clock, 0 = clock comes from outside |
| ser_sck | input | 1 | Clock generated by the peripheral |
| ser_clk_in | output | 1 | Pin level returned to the peripheral in slave mode |
| pd_inhibit_all | input | 1 | Global pulldown block |
| pin_in | input | 1 | Level seen on the pin |
| pin_out | output | 1 | Value driven onto the pin |
| pin_oe | output | 1 | Output buffer enable |
| pin_pd_en | output | 1 | Pulldown enable |

## Verification
The ownership logic is swept over all 256 combinations of these eight inputs: serial enable, master select, direction, data, pulldown-inhibit, global option, peripheral clock and pin level. The register writes in each combination are issued after serial mode is set, so the sweep shows that writes made during peripheral ownership reach storage but not the pin. Directed sequences cover the following: the reset state; read-back and write-only decoding, including unmapped addresses and masked bits; the two-edge latency of the pin read path, by catching the old value one edge after a change; and the same-cycle return to register control when serial mode is switched off.

// File: rtl/pinctl_pkg.sv
package pinctl_pkg;
  localparam logic [7:0] OFF_DATA = 8'h01;
  localparam logic [7:0] OFF_DIR  = 8'h05;
  localparam logic [7:0] OFF_PDI  = 8'h11;

  typedef enum logic [1:0] {
    OWN_PORT   = 2'd0,
    OWN_MASTER = 2'd1,
    OWN_SLAVE  = 2'd2
  } owner_e;
endpackage

// File: rtl/pinctl_sync.sv
module pinctl_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] st;

  for (genvar g = 0; g < STAGES; g++) begin : g_st
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st[g] <= 1'b0;
        else        st[g] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st[g] <= 1'b0;
        else        st[g] <= st[g-1];
      end
    end
  end

  assign q = st[STAGES-1];
endmodule

// File: rtl/pinctl_regs.sv
module pinctl_regs
  import pinctl_pkg::*;
#(
  parameter int ADDR_W  = 5,
  parameter int BIT_IDX = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  input  logic [7:0]        wdata,
  input  logic              pin_s,
  output logic              dir_q,
  output logic              data_q,
  output logic              pdi_q,
  output logic [7:0]        rdata
);
  localparam logic [ADDR_W-1:0] A_DATA = OFF_DATA[ADDR_W-1:0];
  localparam logic [ADDR_W-1:0] A_DIR  = OFF_DIR[ADDR_W-1:0];
  localparam logic [ADDR_W-1:0] A_PDI  = OFF_PDI[ADDR_W-1:0];

  logic wbit;
  assign wbit = wdata[BIT_IDX];

  logic unused_wdata;
  assign unused_wdata = ^wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q  <= 1'b0;
      data_q <= 1'b0;
      pdi_q  <= 1'b0;
    end else if (wr) begin
      if (addr == A_DATA) data_q <= wbit;
      if (addr == A_DIR)  dir_q  <= wbit;
      if (addr == A_PDI)  pdi_q  <= wbit;
    end
  end

  always_comb begin
    rdata = '0;
    if (addr == A_DATA)     rdata[BIT_IDX] = dir_q ? data_q : pin_s;
    else if (addr == A_DIR) rdata[BIT_IDX] = dir_q;
  end

  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !wr |=> $stable({dir_q, data_q, pdi_q}));
  assert_dir_store_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && addr == A_DIR) |=> dir_q == $past(wdata[BIT_IDX]));
  assert_pdi_store_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && addr == A_PDI) |=> pdi_q == $past(wdata[BIT_IDX]));
endmodule

// File: rtl/pinctl_route.sv
module pinctl_route
  import pinctl_pkg::*;
(
  input  logic ser_en,
  input  logic ser_master,
  input  logic ser_sck,
  input  logic pin_in,
  input  logic dir_q,
  input  logic data_q,
  input  logic pdi_q,
  input  logic pd_inhibit_all,
  output logic pin_out,
  output logic pin_oe,
  output logic pin_pd_en,
  output logic ser_clk_in
);
  owner_e own;

  always_comb begin
    if (!ser_en)        own = OWN_PORT;
    else if (ser_master) own = OWN_MASTER;
    else                own = OWN_SLAVE;
  end

  always_comb begin
    pin_out    = 1'b0;
    pin_oe     = 1'b0;
    pin_pd_en  = 1'b0;
    ser_clk_in = 1'b0;
    unique case (own)
      OWN_PORT: begin
        pin_oe    = dir_q;
        pin_out   = data_q;
        pin_pd_en = !dir_q && !pdi_q && !pd_inhibit_all;
      end
      OWN_MASTER: begin
        pin_oe  = 1'b1;
        pin_out = ser_sck;
      end
      OWN_SLAVE: begin
        ser_clk_in = pin_in;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/pinctl_sck_pin.sv
module pinctl_sck_pin #(
  parameter int ADDR_W      = 5,
  parameter int BIT_IDX     = 7,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  input  logic              ser_en,
  input  logic              ser_master,
  input  logic              ser_sck,
  output logic              ser_clk_in,
  input  logic              pd_inhibit_all,
  input  logic              pin_in,
  output logic              pin_out,
  output logic              pin_oe,
  output logic              pin_pd_en
);
  logic pin_s, dir_q, data_q, pdi_q;

  pinctl_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pin_in), .q(pin_s)
  );

  pinctl_regs #(.ADDR_W(ADDR_W), .BIT_IDX(BIT_IDX)) u_regs (
    .clk(clk), .rst_n(rst_n), .addr(reg_addr), .wr(reg_wr),
    .wdata(reg_wdata), .pin_s(pin_s), .dir_q(dir_q), .data_q(data_q),
    .pdi_q(pdi_q), .rdata(reg_rdata)
  );

  pinctl_route u_route (
    .ser_en(ser_en), .ser_master(ser_master), .ser_sck(ser_sck),
    .pin_in(pin_in), .dir_q(dir_q), .data_q(data_q), .pdi_q(pdi_q),
    .pd_inhibit_all(pd_inhibit_all), .pin_out(pin_out), .pin_oe(pin_oe),
    .pin_pd_en(pin_pd_en), .ser_clk_in(ser_clk_in)
  );

  assert_oe_master_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ser_en |-> pin_oe == ser_master);
  assert_master_clk_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ser_en && ser_master) |-> pin_out == ser_sck);
  assert_slave_float_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ser_en && !ser_master) |-> (!pin_oe && ser_clk_in == pin_in));
  assert_pd_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ser_en |-> !pin_pd_en);
  assert_pd_input_R9: assert property (@(posedge clk) disable iff (!rst_n)
    pin_pd_en |-> !pin_oe);
  assert_option_R12: assert property (@(posedge clk) disable iff (!rst_n)
    pd_inhibit_all |-> !pin_pd_en);
endmodule

// File: tb/tb_pinctl_sck_pin.sv
module tb_pinctl_sck_pin;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [4:0] reg_addr = '0;
  logic       reg_wr = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic ser_en = 0, ser_master = 0, ser_sck = 0, ser_clk_in;
  logic pd_inhibit_all = 0, pin_in = 0, pin_out, pin_oe, pin_pd_en;

  int n_chk = 0, n_bad = 0;

  always #2 clk = ~clk;

  pinctl_sck_pin dut (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ser_en(ser_en),
    .ser_master(ser_master), .ser_sck(ser_sck), .ser_clk_in(ser_clk_in),
    .pd_inhibit_all(pd_inhibit_all), .pin_in(pin_in), .pin_out(pin_out),
    .pin_oe(pin_oe), .pin_pd_en(pin_pd_en)
  );

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [4:0] a, logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(logic [4:0] a, output logic [7:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  initial begin
    #400000;
    n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [7:0] r;
    pin_in = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 oe", {7'b0, pin_oe}, 8'h00);
    check("R1 pd_en", {7'b0, pin_pd_en}, 8'h01);
    rd(5'h05, r); check("R1 dir", r, 8'h00);
    rd(5'h01, r); check("R1 R4 pin read", r, 8'h80);
    // R2 decoding
    rd(5'h11, r); check("R2 write-only reads 0", r, 8'h00);
    wr(5'h02, 8'hFF); wr(5'h15, 8'hFF);
    rd(5'h05, r); check("R2 unmapped write", r, 8'h00);
    check("R2 unmapped pd", {7'b0, pin_pd_en}, 8'h01);
    wr(5'h05, 8'h7F); rd(5'h05, r); check("R2 bit7 only", r, 8'h00);
    wr(5'h05, 8'hFF); rd(5'h05, r); check("R2 dir readback", r, 8'h80);
    wr(5'h01, 8'h80); rd(5'h01, r); check("R3 data read", r, 8'h80);
    check("R3 drive", {6'b0, pin_oe, pin_out}, 8'h03);
    // R4 latency with direction cleared
    wr(5'h05, 8'h00);
    @(negedge clk); pin_in = 1'b0;
    @(negedge clk); rd(5'h01, r); check("R4 one edge old", r, 8'h80);
    @(negedge clk); rd(5'h01, r); check("R4 two edges new", r, 8'h00);
    // R10 / R11 writes during master mode, then release
    wr(5'h05, 8'h80); wr(5'h01, 8'h00); wr(5'h11, 8'h00);
    @(negedge clk); ser_en = 1; ser_master = 1; ser_sck = 1;
    #1 check("R6 sck", {6'b0, pin_oe, pin_out}, 8'h03);
    wr(5'h05, 8'h00); wr(5'h01, 8'h80);
    #1 check("R10 unaffected", {6'b0, pin_oe, pin_out}, 8'h03);
    rd(5'h05, r); check("R10 stored dir", r, 8'h00);
    ser_sck = 0; #1 check("R6 follows", {7'b0, pin_out}, 8'h00);
    ser_en = 0; #1;
    check("R11 release", {5'b0, pin_oe, pin_out, pin_pd_en}, 8'h03);
    // exhaustive sweep
    for (int i = 0; i < 256; i++) begin
      logic se, ms, dv, dt, pd, op, sk, pn;
      logic e_oe, e_pd, e_ci;
      {pn, sk, op, pd, dt, dv, ms, se} = i[7:0];
      @(negedge clk);
      ser_en = se; ser_master = ms; ser_sck = sk; pd_inhibit_all = op; pin_in = pn;
      wr(5'h01, {dt, 7'h55});
      wr(5'h05, {dv, 7'h2A});
      wr(5'h11, {pd, 7'h7F});
      repeat (3) @(negedge clk);
      e_oe = se ? ms : dv;
      e_pd = !se && !dv && !pd && !op;
      e_ci = se && !ms && pn;
      check("R5 R3 oe", {7'b0, pin_oe}, {7'b0, e_oe});
      if (e_oe) check("R6 R3 out", {7'b0, pin_out}, {7'b0, se ? sk : dt});
      check("R8 R9 R12 pd", {7'b0, pin_pd_en}, {7'b0, e_pd});
      check("R7 clk_in", {7'b0, ser_clk_in}, {7'b0, e_ci});
      rd(5'h01, r); check("R3 R4 R10 read", r, {dv ? dt : pn, 7'b0});
    end
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule